// File: doc/BRIEF.md
# Secure/Privileged Register Access Filter

This block sits between a bus slave port and a small bank of clock and reset control registers. Every access carries a secure flag and a privileged flag. The block applies two per-bit rules to each access, one for security and one for privilege. It returns filtered read data and drives a per-bit write-enable mask toward the bank. The bank itself lives outside the block: it takes the address and write data from the bus, and it supplies the raw read data for its registers.

The block holds its own configuration registers:
- A security configuration register. Each of its bits marks one group of bank bits as secure.
- A control register that holds the privilege-protection bit and the illegal-access interrupt enable.
- A status register that holds a sticky illegal-access flag.

Two kinds of hit are treated differently:
- A non-secure access that hits a secure bank bit is quietly read as zero, or its write is dropped.
- A non-secure access to the security configuration register is also blocked, and in addition it raises an illegal-access event. That event can drive an interrupt line.

Top module: `reg_access_filter`

## Requirements
- R1: Address map: bank registers at 0..3, security configuration at 4, control at 5, status at 6. A secure access that privilege allows reads `bank_rdata_i` unchanged, and a bank write gives an all-ones mask. Reads return zero when `rd_i` is low and at unmapped addresses. The mask is zero for any non-bank address.
- R2: Bit b of bank register r belongs to group ((b div 4) + r) mod 4. The group is secure while security configuration bit g is 1. A non-secure read returns zero on secure bits and passes the other bits. It raises no event.
- R3: A non-secure bank write gives a mask with zeros on secure bits and ones on all other bits. It raises no event.
- R4: A non-secure read of the security configuration register returns zero. The cycle after the access, `illegal_o` is high.
- R5: A non-secure write to the security configuration register leaves its contents unchanged. The cycle after the access, `illegal_o` is high.
- R6: `irq_o` follows the illegal-access pulse only while control bit 1 (interrupt enable) is 1.
- R7: With control bit 0 (privilege protection) at 0, unprivileged accesses read and write every register. The one exception is control bit 0 itself, which only a privileged write changes.
- R8: With privilege protection at 1:
  - Unprivileged reads return zero.
  - Unprivileged writes give a zero mask and change no configuration register.
  - Privileged accesses keep full access.
  - The bank write mask is the AND of the security mask and the privilege mask.
- R9: Status bit 0 becomes 1 with each illegal-access pulse. A secure write, allowed by privilege, with data bit 0 set clears it. A non-secure write to the status register leaves it unchanged.
- R10: After reset the following are all 0: the security configuration, privilege protection, interrupt enable, the status flag, `illegal_o` and `irq_o`.
- R11: `illegal_o` is high for exactly one cycle per offending access cycle. An access that both reads and writes in one cycle gives one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| secure_i | input | 1 | Access is secure |
| priv_i | input | 1 | Access is privileged |
| bank_rdata_i | input | 16 | Raw read data from the bank register addressed |
| rdata_o | output | 16 | Filtered read data |
| bank_wdata_o | output | 16 | Write data toward the bank |
| bank_wmask_o | output | 16 | Per-bit write enable toward the bank |
| illegal_o | output | 1 | Illegal-access pulse |
| irq_o | output | 1 | Illegal-access interrupt, gated by the enable |

## Verification
The assertions check the following on every cycle:
- Non-secure reads and writes never expose or enable a bit marked secure.
- Unprivileged reads return zero under protection.
- Blocked writes leave the security configuration and the protection bit stable.
- Every illegal pulse has an offending access one cycle earlier, and it comes with the sticky flag set.
- The interrupt is never high without its enable.

The group-to-bit mapping for each configuration value can only be shown by the bench's scenarios. The same holds for:
- the exact filtered read values and masks;
- the write-1-to-clear sequence of the flag;
- the interplay of protection with the secure state.

// File: rtl/raf_pkg.sv
package raf_pkg;
  // group owning bit b of bank register r; shifts per register so groups span registers
  function automatic int unsigned grp_of(int unsigned reg_idx, int unsigned bit_idx,
                                         int unsigned slice, int unsigned n_grp);
    return ((bit_idx / slice) + reg_idx) % n_grp;
  endfunction
endpackage

// File: rtl/raf_sec_mask.sv
module raf_sec_mask #(
  parameter int DATA_W = 16,
  parameter int N_REG  = 4,
  parameter int N_GRP  = 4,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_GRP-1:0]  sec_cfg_i,
  output logic [DATA_W-1:0] sec_bits_o
);
  localparam int SLICE = DATA_W / N_GRP;
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;
  localparam logic [ADDR_W-1:0] BANK_LIM = ADDR_W'(N_REG);

  logic [N_REG-1:0][DATA_W-1:0] map;

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int unsigned GRP = raf_pkg::grp_of(r, b, SLICE, N_GRP);
      assign map[r][b] = sec_cfg_i[GRP];
    end
  end

  assign sec_bits_o = (addr_i < BANK_LIM) ? map[addr_i[IDX_W-1:0]] : '0;
endmodule

// File: rtl/raf_cfg_regs.sv
module raf_cfg_regs #(
  parameter int DATA_W = 16,
  parameter int N_REG  = 4,
  parameter int N_GRP  = 4,
  parameter int ADDR_W = 4,
  parameter int CFG_W  = (N_GRP > 2) ? N_GRP : 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              secure_i,
  input  logic              priv_i,
  output logic [N_GRP-1:0]  sec_cfg_o,
  output logic              priv_ok_o,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              illegal_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] SEC_ADDR = ADDR_W'(N_REG);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(N_REG + 1);
  localparam logic [ADDR_W-1:0] STA_ADDR = ADDR_W'(N_REG + 2);

  logic [N_GRP-1:0] sec_cfg_q;
  logic prot_q, irq_en_q, flag_q, ill_q;
  logic hit_sec, hit_ctl, hit_sta, priv_ok;
  logic sec_wr, ctl_wr, flag_clr, evt;

  assign hit_sec = addr_i == SEC_ADDR;
  assign hit_ctl = addr_i == CTL_ADDR;
  assign hit_sta = addr_i == STA_ADDR;
  assign priv_ok = priv_i | ~prot_q;

  assign sec_wr   = wr_i & hit_sec & secure_i & priv_ok;
  assign ctl_wr   = wr_i & hit_ctl & priv_ok;
  assign flag_clr = wr_i & hit_sta & secure_i & priv_ok & cfg_wdata_i[0];
  assign evt      = (rd_i | wr_i) & hit_sec & ~secure_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_cfg_q <= '0;
      prot_q    <= 1'b0;
      irq_en_q  <= 1'b0;
      flag_q    <= 1'b0;
      ill_q     <= 1'b0;
    end else begin
      if (sec_wr) sec_cfg_q <= cfg_wdata_i[N_GRP-1:0];
      if (ctl_wr) begin
        irq_en_q <= cfg_wdata_i[1];
        if (priv_i) prot_q <= cfg_wdata_i[0];  // protection bit: privileged writers only
      end
      if (evt) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      ill_q <= evt;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (hit_sec && secure_i && priv_ok) cfg_rdata_o = DATA_W'(sec_cfg_q);
    if (hit_ctl && priv_ok)             cfg_rdata_o = DATA_W'({irq_en_q, prot_q});
    if (hit_sta && priv_ok)             cfg_rdata_o = DATA_W'(flag_q);
  end

  assign sec_cfg_o = sec_cfg_q;
  assign priv_ok_o = priv_ok;
  assign illegal_o = ill_q;
  assign irq_o     = ill_q & irq_en_q;

  AST_EVT_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past((rd_i | wr_i) && addr_i == SEC_ADDR && !secure_i)); // R4
  AST_SECCFG_NS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_sec && !secure_i) |=> $stable(sec_cfg_q)); // R5
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_q); // R6
  AST_PROT_UNPRIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_ctl && !priv_i) |=> $stable(prot_q)); // R7
  AST_UNPRIV_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !priv_i && prot_q) |=> ($stable(sec_cfg_q) && $stable(irq_en_q))); // R8
  AST_FLAG_ON_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> flag_q); // R9
endmodule

// File: rtl/raf_data_path.sv
module raf_data_path #(
  parameter int DATA_W = 16,
  parameter int N_REG  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              secure_i,
  input  logic              priv_ok_i,
  input  logic [DATA_W-1:0] sec_bits_i,
  input  logic [DATA_W-1:0] bank_rdata_i,
  input  logic [DATA_W-1:0] cfg_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] wmask_o
);
  localparam logic [ADDR_W-1:0] BANK_LIM = ADDR_W'(N_REG);

  logic in_bank;
  logic [DATA_W-1:0] sec_allow, priv_allow, allow;

  assign in_bank    = addr_i < BANK_LIM;
  assign sec_allow  = secure_i ? '1 : ~sec_bits_i;
  assign priv_allow = {DATA_W{priv_ok_i}};
  assign allow      = sec_allow & priv_allow;

  assign wmask_o = (wr_i && in_bank) ? allow : '0;

  always_comb begin
    if (!rd_i)        rdata_o = '0;
    else if (in_bank) rdata_o = bank_rdata_i & allow;
    else              rdata_o = cfg_rdata_i;
  end

  AST_NS_RD_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !secure_i && in_bank) |-> ((rdata_o & sec_bits_i) == '0)); // R2
  AST_NS_WR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !secure_i) |-> ((wmask_o & sec_bits_i) == '0)); // R3
  AST_UNPRIV_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !priv_ok_i) |-> (rdata_o == '0)); // R8
endmodule

// File: rtl/reg_access_filter.sv
module reg_access_filter #(
  parameter int DATA_W = 16,
  parameter int N_REG  = 4,
  parameter int N_GRP  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              secure_i,
  input  logic              priv_i,
  input  logic [DATA_W-1:0] bank_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] bank_wdata_o,
  output logic [DATA_W-1:0] bank_wmask_o,
  output logic              illegal_o,
  output logic              irq_o
);
  localparam int CFG_W = (N_GRP > 2) ? N_GRP : 2;

  logic [N_GRP-1:0]  sec_cfg;
  logic [DATA_W-1:0] sec_bits, cfg_rdata;
  logic              priv_ok;

  raf_cfg_regs #(.DATA_W(DATA_W), .N_REG(N_REG), .N_GRP(N_GRP), .ADDR_W(ADDR_W), .CFG_W(CFG_W))
  i_cfg (
    .clk_i, .rst_ni, .addr_i,
    .cfg_wdata_i(wdata_i[CFG_W-1:0]),
    .wr_i, .rd_i, .secure_i, .priv_i,
    .sec_cfg_o(sec_cfg), .priv_ok_o(priv_ok), .cfg_rdata_o(cfg_rdata),
    .illegal_o, .irq_o
  );

  raf_sec_mask #(.DATA_W(DATA_W), .N_REG(N_REG), .N_GRP(N_GRP), .ADDR_W(ADDR_W))
  i_mask (.addr_i, .sec_cfg_i(sec_cfg), .sec_bits_o(sec_bits));

  raf_data_path #(.DATA_W(DATA_W), .N_REG(N_REG), .ADDR_W(ADDR_W))
  i_dp (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .secure_i,
    .priv_ok_i(priv_ok), .sec_bits_i(sec_bits),
    .bank_rdata_i, .cfg_rdata_i(cfg_rdata),
    .rdata_o, .wmask_o(bank_wmask_o)
  );

  assign bank_wdata_o = wdata_i;
endmodule

// File: tb/test_reg_access_filter.sv
module test_reg_access_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, bank_rdata, rdata, bank_wdata, wmask;
  logic wr = 1'b0, rd = 1'b0, sec = 1'b0, priv = 1'b0, ill, irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign bank_rdata = 16'hA5C3 ^ ({4{addr}} * 16'h0101);

  reg_access_filter i_reg_access_filter (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .secure_i(sec), .priv_i(priv), .bank_rdata_i(bank_rdata), .rdata_o(rdata),
    .bank_wdata_o(bank_wdata), .bank_wmask_o(wmask), .illegal_o(ill), .irq_o(irq)
  );

  typedef struct {
    logic [15:0] rd;
    logic [15:0] wm;
    logic        ill;
    logic        irq;
    string       tag;
  } item_t;
  item_t q[$];

  // specification model state
  logic [3:0] m_sec = '0;
  logic m_prot = 0, m_irqen = 0, m_flag = 0;

  task automatic check(input string tag, input string what, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] secmask(input int r);
    logic [15:0] m;
    for (int b = 0; b < 16; b++) m[b] = m_sec[((b / 4) + r) % 4];
    return m;
  endfunction

  task automatic acc(input logic [3:0] a, input logic w, input logic r, input logic s,
                     input logic p, input logic [15:0] wd, input string tag);
    item_t it;
    logic pok;
    logic [15:0] allow, bdat;
    @(negedge clk);
    addr = a; wr = w; rd = r; sec = s; priv = p; wdata = wd;
    bdat = 16'hA5C3 ^ ({4{a}} * 16'h0101);
    pok = p | ~m_prot;
    it.rd = '0; it.wm = '0; it.ill = 0; it.tag = tag;
    if (a < 4) begin
      allow = (s ? 16'hFFFF : ~secmask(a)) & (pok ? 16'hFFFF : 16'h0000);
      if (r) it.rd = bdat & allow;
      if (w) it.wm = allow;
    end else if (a == 4) begin
      if (r && s && pok) it.rd = {12'h0, m_sec};
      it.ill = (r | w) & ~s;
      if (w && s && pok) m_sec = wd[3:0];
    end else if (a == 5) begin
      if (r && pok) it.rd = {14'h0, m_irqen, m_prot};
      if (w && pok) begin
        m_irqen = wd[1];
        if (p) m_prot = wd[0];
      end
    end else if (a == 6) begin
      if (r && pok) it.rd = {15'h0, m_flag};
      if (w && s && pok && wd[0]) m_flag = 0;
    end
    if (it.ill) m_flag = 1;
    it.irq = it.ill & m_irqen;
    q.push_back(it);
  endtask

  task automatic idle();
    acc(4'h7, 0, 0, 0, 0, 16'h0, "R1");
  endtask

  // monitor: combinational outputs belong to the current item, pulses to the previous one
  initial begin
    item_t cur, prev;
    bit have_prev = 0;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        cur = q.pop_front();
        if (have_prev) begin
          check(prev.tag, "illegal", {15'h0, ill}, {15'h0, prev.ill});
          check(prev.tag, "irq", {15'h0, irq}, {15'h0, prev.irq});
        end
        check(cur.tag, "rdata", rdata, cur.rd);
        check(cur.tag, "wmask", wmask, cur.wm);
        prev = cur;
        have_prev = 1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "illegal_in_reset", {15'h0, ill}, 16'h0);
    check("R10", "irq_in_reset", {15'h0, irq}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R10", "rdata_idle", rdata, 16'h0);
    check("R10", "wmask_idle", wmask, 16'h0);
    // R10: all open after reset
    acc(4, 0, 1, 1, 0, 0, "R10");
    acc(5, 0, 1, 0, 0, 0, "R10");
    acc(6, 0, 1, 0, 0, 0, "R10");
    acc(0, 1, 1, 0, 0, 16'h1234, "R10");
    acc(3, 0, 1, 0, 0, 0, "R10");
    // R1 program groups 0 and 2 secure, read back, unmapped
    acc(4, 1, 0, 1, 1, 16'h0005, "R1");
    acc(4, 0, 1, 1, 1, 0, "R1");
    acc(9, 1, 1, 1, 1, 16'hFFFF, "R1");
    acc(5, 0, 0, 1, 1, 0, "R1");
    // R2 R3 non-secure masking, R1 secure full
    for (int r = 0; r < 4; r++) begin
      acc(r[3:0], 0, 1, 0, 0, 0, "R2");
      acc(r[3:0], 1, 0, 0, 1, 16'hBEEF, "R3");
      acc(r[3:0], 1, 1, 1, 0, 16'h0F0F, "R1");
    end
    // R4 R5 illegal config accesses, irq disabled
    acc(4, 0, 1, 0, 1, 0, "R4");
    idle();
    acc(4, 1, 0, 0, 1, 16'h000F, "R5");
    acc(4, 0, 1, 1, 1, 0, "R5");
    // R6 enable irq (unprivileged allowed), R7 protection bit needs privilege
    acc(5, 1, 0, 0, 0, 16'h0003, "R7");
    acc(5, 0, 1, 0, 0, 0, "R7");
    acc(4, 0, 1, 0, 0, 0, "R6");
    idle();
    // R11 back-to-back and combined rd+wr
    acc(4, 0, 1, 0, 0, 0, "R11");
    acc(4, 1, 1, 0, 1, 16'h0, "R11");
    idle();
    idle();
    // R8 protection on
    acc(5, 1, 0, 1, 1, 16'h0003, "R8");
    acc(5, 0, 1, 1, 1, 0, "R8");
    acc(0, 0, 1, 1, 0, 0, "R8");
    acc(1, 1, 1, 0, 0, 16'hFFFF, "R8");
    acc(4, 1, 0, 1, 0, 16'h0000, "R8");
    acc(5, 1, 0, 0, 0, 16'h0000, "R8");
    acc(4, 0, 1, 1, 1, 0, "R8");
    acc(5, 0, 1, 0, 1, 0, "R8");
    acc(2, 1, 1, 0, 1, 16'h5555, "R8");
    acc(2, 1, 1, 1, 1, 16'h5555, "R8");
    acc(4, 0, 1, 0, 0, 0, "R8");
    // R9 sticky flag
    acc(6, 0, 1, 0, 1, 0, "R9");
    acc(6, 1, 0, 0, 1, 16'h0001, "R9");
    acc(6, 0, 1, 1, 1, 0, "R9");
    acc(6, 1, 0, 1, 0, 16'h0001, "R9");
    acc(6, 0, 1, 1, 1, 0, "R9");
    acc(6, 1, 0, 1, 1, 16'h0001, "R9");
    acc(6, 0, 1, 0, 1, 0, "R9");
    // R2 different group pattern, protection off again
    acc(5, 1, 0, 1, 1, 16'h0000, "R7");
    acc(4, 1, 0, 1, 0, 16'h000A, "R2");
    for (int r = 0; r < 4; r++) acc(r[3:0], 1, 1, 0, 0, 16'hFFFF, "R2");
    idle();
    idle();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule